// File: doc/BRIEF.md
# Command-Driven Random Number Generator with Automatic Reseed

This block is the front end of a hardware random source. Software talks to it through a small 32-bit register port. It writes a command word asking for fresh output or for a reseed. It polls status or waits for the interrupt line. It then reads up to eight 32-bit result words and acknowledges the ready flag by writing it back. Entropy comes in one bit per clock on `ent_bit` and is folded into a 32-bit linear feedback shift register. That register stands in for the conditioning stage, and its state is copied into the result words, one word per clock, while a request is served.

Three status flags describe the sequencer: seeded, generating and reseeding. At reset the block runs an initial seed before it accepts work. A programmable limit counts served requests in 16-byte units. When a finished request brings the count up to the limit, a reseed starts without software involvement. A command that arrives while the sequencer is busy stays pending and runs as soon as the sequencer is idle again.

Top module: `rng_cmd_core`

## Requirements
- R1: After reset is released, status (offset 0x04) reads 0x8000_0000 (bit 31 = reseeding, bit 9 = seeded clear) for exactly 16 clock cycles. It then reads 0x0000_0200. Interrupt status bit 1 is then set and the command register reads 0.
- R2: Offset 0xF0 reads the constant 0x0000_46BC. Offsets with no register (for example 0x0C and 0x44) read 0.
- R3: The command register at offset 0x00 takes 0x1 (generate), 0x2 (reseed) or 0x0 (none). Any other written value is ignored. A valid command reads back until the idle sequencer takes it, one cycle after it is written, and then reads 0.
- R4: A generate command sets status bit 30, so status reads 0x4000_0200, for one cycle per output word. In the cycle that generation ends, interrupt status bit 0 (ready) sets.
- R5: Mode bit 3 at offset 0x08 selects the output size: 0 gives four words (offsets 0x20 to 0x2C), 1 gives eight words (0x20 to 0x3C). All produced words are nonzero. In four-word mode, offsets 0x30 to 0x3C read 0, even if an earlier request filled them.
- R6: Every request loads fresh output: word 0 differs between successive requests.
- R7: Interrupt status at offset 0x14 is write-one-to-clear on bits 1:0. Writing 0 to a bit leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R8: A reseed command sets status bit 31 for 16 cycles and clears the request count. When the reseed ends, interrupt status bit 1 sets.
- R9: Offset 0x60 holds a request limit L. A 128-bit request counts 1 and a 256-bit request counts 2. If L is nonzero and a finished request brings the count to L or more, reseeding starts in the same cycle that generation ends. L = 0 disables this.
- R10: A generate command written while a reseed runs stays pending and starts one cycle after the reseed ends.
- R11: Interrupt enable at offset 0x10 has a global bit 31, a seed-done bit 1 and a ready bit 0. `irq` is high exactly when the global bit is set and some enabled status bit is set.
- R12: Generating and reseeding are never reported together, and generation never runs before the first seed completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_bit | input | 1 | One raw entropy sample per clock |
| wr_en | input | 1 | Register write strobe for the current `addr` |
| addr | input | 8 | Byte offset of the register being accessed |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A sequencer stuck in the wrong state shows on the status word at the next sampled cycle, because the generating and reseeding flags come straight from the state. The bench therefore checks the exact status word at cycle-exact points: the last reseed cycle, the first and last generate cycles, and the first idle cycle. An error in the request counter or its limit compare appears only at the end of the request that should have started a reseed, as a missing bit 31 and a missing seed-done bit 16 cycles later. A wrong word index or size latch shows on the next read of the result words: upper words would be visible in four-word mode, or zero words would appear in eight-word mode.

// File: rtl/rng_cmd_pkg.sv
// Shared encodings for the random number generator front end.
// Assumes an 8-bit byte-addressed register port with 32-bit words.
package rng_cmd_pkg;

    typedef enum logic [1:0] {
        SQ_SEED = 2'd0,
        SQ_IDLE = 2'd1,
        SQ_GEN  = 2'd2
    } seq_state_e;

    localparam logic [1:0] OP_NOP  = 2'd0;
    localparam logic [1:0] OP_RAND = 2'd1;
    localparam logic [1:0] OP_SEED = 2'd2;

    localparam logic [7:0] A_CMD    = 8'h00;
    localparam logic [7:0] A_STAT   = 8'h04;
    localparam logic [7:0] A_MODE   = 8'h08;
    localparam logic [7:0] A_IE     = 8'h10;
    localparam logic [7:0] A_ISTAT  = 8'h14;
    localparam logic [7:0] A_RES0   = 8'h20;
    localparam logic [7:0] A_RESEED = 8'h60;
    localparam logic [7:0] A_VER    = 8'hF0;

    localparam int STAT_SEEDED_BIT = 9;
    localparam int STAT_GEN_BIT    = 30;
    localparam int STAT_RESEED_BIT = 31;
    localparam int MODE_WIDE_BIT   = 3;
    localparam int IE_GLOBAL_BIT   = 31;

    localparam logic [31:0] VERSION_ID = 32'h0000_46BC;

endpackage

// File: rtl/rng_lfsr_mix.sv
// Entropy mixer: a Fibonacci LFSR whose feedback is XORed with one
// entropy bit per clock. Steps every cycle. Assumes TAP_A/TAP_B < W-1.
// A zero next state is replaced by INIT so the output is never zero.
module rng_lfsr_mix #(
    parameter int          W     = 32,
    parameter int          TAP_A = 21,
    parameter int          TAP_B = 1,
    parameter logic [31:0] INIT  = 32'h1ACE_B00C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ent_bit,
    output logic [W-1:0] state_o
);

    logic [W-1:0] s_q;
    logic [W-1:0] s_n;
    logic         fb;

    // Next state: shift in feedback mixed with entropy, avoid lock-up at zero.
    always_comb begin
        fb  = s_q[W-1] ^ s_q[TAP_A] ^ s_q[TAP_B] ^ s_q[0] ^ ent_bit;
        s_n = {s_q[W-2:0], fb};
        if (s_n == '0) begin
            s_n = W'(INIT);
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= W'(INIT);
        end else begin
            s_q <= s_n;
        end
    end

    assign state_o = s_q;

endmodule

// File: rtl/rng_seq_ctrl.sv
// Sequencer: runs the initial seed, accepts pending commands when idle,
// writes one result word per generate cycle and tracks the request count
// for automatic reseeding. Assumes NWORDS is a power of two >= 2.
module rng_seq_ctrl
    import rng_cmd_pkg::*;
#(
    parameter int SEED_CYCLES = 16,
    parameter int NWORDS      = 8,
    parameter int CNT_W       = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                cmd_pend,
    input  logic                      wide_req,
    input  logic [CNT_W-1:0]          reseed_limit,
    output seq_state_e                state_o,
    output logic                      seeded_o,
    output logic                      wide_o,
    output logic                      accept_o,
    output logic                      word_we_o,
    output logic [$clog2(NWORDS)-1:0] word_idx_o,
    output logic                      gen_done_o,
    output logic                      seed_done_o
);

    localparam int IDX_W = $clog2(NWORDS);
    localparam int SPAN  = (SEED_CYCLES > NWORDS) ? SEED_CYCLES : NWORDS;
    localparam int CYC_W = $clog2(SPAN) + 1;
    localparam int EXT_W = CNT_W + 1;
    localparam logic [CYC_W-1:0] SEED_LAST   = CYC_W'(SEED_CYCLES - 1);
    localparam logic [CYC_W-1:0] WIDE_LAST   = CYC_W'(NWORDS - 1);
    localparam logic [CYC_W-1:0] NARROW_LAST = CYC_W'(NWORDS / 2 - 1);

    seq_state_e       state_q;
    logic [CYC_W-1:0] cnt_q;
    logic             seeded_q;
    logic             wide_q;
    logic [CNT_W-1:0] req_q;
    logic [EXT_W-1:0] req_ext;
    logic [CNT_W-1:0] req_sat;
    logic             auto_go;

    // Decode of the current step: acceptance, word writes, end events.
    always_comb begin
        accept_o    = (state_q == SQ_IDLE) && ((cmd_pend == OP_RAND) || (cmd_pend == OP_SEED));
        word_we_o   = (state_q == SQ_GEN);
        word_idx_o  = cnt_q[IDX_W-1:0];
        gen_done_o  = (state_q == SQ_GEN) && (cnt_q == (wide_q ? WIDE_LAST : NARROW_LAST));
        seed_done_o = (state_q == SQ_SEED) && (cnt_q == SEED_LAST);
    end

    // Request count after the current request, saturating, and limit compare.
    always_comb begin
        req_ext = {1'b0, req_q} + EXT_W'(wide_q ? 2 : 1);
        req_sat = req_ext[CNT_W] ? '1 : req_ext[CNT_W-1:0];
        auto_go = (reseed_limit != '0) && (req_sat >= reseed_limit);
    end

    // Sequencer state, cycle counter, seeded flag, size latch, request count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_SEED;
            cnt_q    <= '0;
            seeded_q <= 1'b0;
            wide_q   <= 1'b0;
            req_q    <= '0;
        end else begin
            case (state_q)
                SQ_SEED: begin
                    if (seed_done_o) begin
                        state_q  <= SQ_IDLE;
                        cnt_q    <= '0;
                        seeded_q <= 1'b1;
                        req_q    <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_IDLE: begin
                    cnt_q <= '0;
                    if (cmd_pend == OP_RAND) begin
                        state_q <= SQ_GEN;
                        wide_q  <= wide_req;
                    end else if (cmd_pend == OP_SEED) begin
                        state_q <= SQ_SEED;
                    end
                end
                SQ_GEN: begin
                    if (gen_done_o) begin
                        cnt_q   <= '0;
                        req_q   <= req_sat;
                        state_q <= auto_go ? SQ_SEED : SQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= SQ_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign state_o  = state_q;
    assign seeded_o = seeded_q;
    assign wide_o   = wide_q;

endmodule

// File: rtl/rng_result_bank.sv
// Result word storage: NWORDS registers, one written per cycle by index.
// Reads are combinational; the upper half reads zero when hide_upper is set.
// Assumes NWORDS is a power of two.
module rng_result_bank #(
    parameter int NWORDS = 8,
    parameter int W      = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(NWORDS)-1:0] widx,
    input  logic [W-1:0]              wdata,
    input  logic [$clog2(NWORDS)-1:0] ridx,
    input  logic                      hide_upper,
    output logic [W-1:0]              rdata
);

    localparam int IDX_W = $clog2(NWORDS);

    logic [NWORDS-1:0][W-1:0] bank;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [W-1:0] word_q;

        // Capture the mixer output when this word is the one being filled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                word_q <= wdata;
            end
        end

        assign bank[g] = word_q;
    end

    // Read select with masking of the words a narrow request did not fill.
    always_comb begin
        if (hide_upper && (ridx >= IDX_W'(NWORDS / 2))) begin
            rdata = '0;
        end else begin
            rdata = bank[ridx];
        end
    end

endmodule

// File: rtl/rng_irq_unit.sv
// Interrupt enable and status: status bits are set by sequencer events and
// cleared by writing ones; a set beats a clear in the same cycle.
module rng_irq_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ie_we,
    input  logic [2:0] ie_wbits,
    input  logic       st_we,
    input  logic [1:0] st_clr,
    input  logic       set_ready,
    input  logic       set_seed,
    output logic       ie_glob,
    output logic       ie_seed,
    output logic       ie_ready,
    output logic [1:0] istat,
    output logic       irq
);

    logic [1:0] clr_mask;

    // Enable bits: {global, seed-done, ready}.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_glob  <= 1'b0;
            ie_seed  <= 1'b0;
            ie_ready <= 1'b0;
        end else if (ie_we) begin
            ie_glob  <= ie_wbits[2];
            ie_seed  <= ie_wbits[1];
            ie_ready <= ie_wbits[0];
        end
    end

    // Clear mask from a status write.
    always_comb begin
        clr_mask = st_we ? st_clr : 2'b00;
    end

    // Status bits: write-one-to-clear, hardware set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            istat <= 2'b00;
        end else begin
            istat <= (istat & ~clr_mask) | {set_seed, set_ready};
        end
    end

    // Interrupt line.
    always_comb begin
        irq = ie_glob & ((ie_seed & istat[1]) | (ie_ready & istat[0]));
    end

endmodule

// File: rtl/rng_cmd_core.sv
// Top of the random number generator front end: register decode, pending
// command, mode and reseed limit registers, and the read multiplexer.
// Assumes single-cycle writes and a combinational read path.
module rng_cmd_core
    import rng_cmd_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          SEED_CYCLES = 16,
    parameter int          NWORDS      = 8,
    parameter int          CNT_W       = 16,
    parameter logic [31:0] LFSR_INIT   = 32'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_bit,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);

    localparam int DW    = 32;
    localparam int IDX_W = $clog2(NWORDS);
    localparam int RES_END = int'(A_RES0) + 4 * NWORDS;

    seq_state_e        seq_state;
    logic              seeded;
    logic              wide_q;
    logic              accept;
    logic              word_we;
    logic [IDX_W-1:0]  word_idx;
    logic              gen_done;
    logic              seed_done;
    logic [1:0]        cmd_pend;
    logic              mode_wide;
    logic [CNT_W-1:0]  reseed_limit;
    logic [DW-1:0]     mix_word;
    logic [DW-1:0]     res_word;
    logic [IDX_W-1:0]  rd_idx;
    logic              in_res;
    logic              ie_glob;
    logic              ie_seed;
    logic              ie_ready;
    logic [1:0]        istat;
    logic              cmd_wr;
    logic              cmd_ok;

    // Write decode for the command register and command validity.
    always_comb begin
        cmd_wr = wr_en && (addr == ADDR_W'(A_CMD));
        cmd_ok = (wdata == 32'(OP_NOP)) || (wdata == 32'(OP_RAND)) || (wdata == 32'(OP_SEED));
    end

    // Pending command: a valid write replaces it, acceptance returns it to none.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_pend <= OP_NOP;
        end else if (cmd_wr && cmd_ok) begin
            cmd_pend <= wdata[1:0];
        end else if (accept) begin
            cmd_pend <= OP_NOP;
        end
    end

    // Mode and reseed limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_wide    <= 1'b0;
            reseed_limit <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_MODE)) begin
                mode_wide <= wdata[MODE_WIDE_BIT];
            end
            if (addr == ADDR_W'(A_RESEED)) begin
                reseed_limit <= wdata[CNT_W-1:0];
            end
        end
    end

    rng_lfsr_mix #(
        .W    (DW),
        .TAP_A(21),
        .TAP_B(1),
        .INIT (LFSR_INIT)
    ) u_mix (
        .clk    (clk),
        .rst_n  (rst_n),
        .ent_bit(ent_bit),
        .state_o(mix_word)
    );

    rng_seq_ctrl #(
        .SEED_CYCLES(SEED_CYCLES),
        .NWORDS     (NWORDS),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_pend    (cmd_pend),
        .wide_req    (mode_wide),
        .reseed_limit(reseed_limit),
        .state_o     (seq_state),
        .seeded_o    (seeded),
        .wide_o      (wide_q),
        .accept_o    (accept),
        .word_we_o   (word_we),
        .word_idx_o  (word_idx),
        .gen_done_o  (gen_done),
        .seed_done_o (seed_done)
    );

    rng_result_bank #(
        .NWORDS(NWORDS),
        .W     (DW)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (word_we),
        .widx      (word_idx),
        .wdata     (mix_word),
        .ridx      (rd_idx),
        .hide_upper(!wide_q),
        .rdata     (res_word)
    );

    rng_irq_unit u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ie_we    (wr_en && (addr == ADDR_W'(A_IE))),
        .ie_wbits ({wdata[IE_GLOBAL_BIT], wdata[1], wdata[0]}),
        .st_we    (wr_en && (addr == ADDR_W'(A_ISTAT))),
        .st_clr   (wdata[1:0]),
        .set_ready(gen_done),
        .set_seed (seed_done),
        .ie_glob  (ie_glob),
        .ie_seed  (ie_seed),
        .ie_ready (ie_ready),
        .istat    (istat),
        .irq      (irq)
    );

    // Result window decode: word-aligned offsets inside the result range.
    always_comb begin
        in_res = (addr >= ADDR_W'(A_RES0)) && (addr < ADDR_W'(RES_END)) && (addr[1:0] == 2'b00);
        rd_idx = IDX_W'((addr - ADDR_W'(A_RES0)) >> 2);
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CMD)) begin
            rdata = {30'b0, cmd_pend};
        end else if (addr == ADDR_W'(A_STAT)) begin
            rdata[STAT_RESEED_BIT] = (seq_state == SQ_SEED);
            rdata[STAT_GEN_BIT]    = (seq_state == SQ_GEN);
            rdata[STAT_SEEDED_BIT] = seeded;
        end else if (addr == ADDR_W'(A_MODE)) begin
            rdata[MODE_WIDE_BIT] = mode_wide;
        end else if (addr == ADDR_W'(A_IE)) begin
            rdata = {ie_glob, 29'b0, ie_seed, ie_ready};
        end else if (addr == ADDR_W'(A_ISTAT)) begin
            rdata = {30'b0, istat};
        end else if (addr == ADDR_W'(A_RESEED)) begin
            rdata = DW'(reseed_limit);
        end else if (addr == ADDR_W'(A_VER)) begin
            rdata = VERSION_ID;
        end else if (in_res) begin
            rdata = res_word;
        end
    end

endmodule

// File: rtl/rng_cmd_core_chk.sv
// Property checker for rng_cmd_core, attached with bind below.
// Observes ports plus sequencer, command and interrupt state.
module rng_cmd_core_chk
    import rng_cmd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NWORDS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              irq,
    input seq_state_e        state,
    input logic              seeded,
    input logic              wide_q,
    input logic [1:0]        cmd_pend,
    input logic [1:0]        istat,
    input logic              ie_glob
);

    // R3: an idle sequencer takes a pending generate on the next edge.
    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && cmd_pend == OP_RAND && !wr_en) |=> (state == SQ_GEN && cmd_pend == OP_NOP));

    // R4: leaving generation always raises the ready status bit.
    p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == SQ_GEN) |-> istat[0]);

    // R5: upper result words read zero after a narrow request.
    p_upper_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_q && addr >= ADDR_W'(int'(A_RES0) + 2 * NWORDS) && addr < ADDR_W'(int'(A_RES0) + 4 * NWORDS))
        |-> rdata == '0);

    // R8: the end of any seed leaves the block seeded with seed-done set.
    p_seed_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == SQ_SEED) |-> (seeded && istat[1]));

    // R10: a generate request waits while a reseed runs.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SEED && cmd_pend == OP_RAND && !wr_en) |=> cmd_pend == OP_RAND);

    // R11: the interrupt line needs the global enable and a pending status bit.
    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_glob && istat != 2'b00));

    // R12: generation only happens once seeded.
    p_gen_seeded_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_GEN) |-> seeded);

endmodule

bind rng_cmd_core rng_cmd_core_chk #(
    .ADDR_W(ADDR_W),
    .NWORDS(NWORDS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .irq     (irq),
    .state   (seq_state),
    .seeded  (seeded),
    .wide_q  (wide_q),
    .cmd_pend(cmd_pend),
    .istat   (istat),
    .ie_glob (ie_glob)
);

// File: tb/sim_rng_cmd_core.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sim_rng_cmd_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ent_bit = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;

    int          checks = 0;
    int          fails = 0;
    logic [15:0] ent_lfsr = 16'hBEEF;
    logic [31:0] saved_w0;

    always #5 clk = ~clk;

    rng_cmd_core u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .ent_bit(ent_bit),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .irq    (irq)
    );

    // Entropy source: a bench LFSR updated away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            ent_lfsr = {ent_lfsr[14:0], ent_lfsr[15] ^ ent_lfsr[13] ^ ent_lfsr[12] ^ ent_lfsr[10]};
            ent_bit  = ent_lfsr[0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_ne(input string tag, input logic [31:0] act, input logic [31:0] bad);
        checks++;
        if (act === bad) begin
            fails++;
            $display("FAIL %s actual=%h expected=not %h", tag, act, bad);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    // One generate request with cycle-exact status checks (R3, R4, R12).
    task automatic gen_req(input logic wide, input logic [31:0] exp_end);
        int          n;
        logic [31:0] d;
        n = wide ? 8 : 4;
        wr(8'h08, wide ? 32'h8 : 32'h0);
        wr(8'h00, 32'h1);
        rd_chk("R3 pending command reads back", 8'h00, 32'h1);
        step(1);
        rd_chk("R4 R12 generating status", 8'h04, 32'h4000_0200);
        rd_chk("R3 command returns to none", 8'h00, 32'h0);
        step(n - 1);
        rd_chk("R4 still generating on last word", 8'h04, 32'h4000_0200);
        step(1);
        rd_chk("R4 R9 status after generation", 8'h04, exp_end);
        rd(8'h14, d);
        chk("R4 ready bit set", d & 32'h1, 32'h1);
    endtask

    task automatic t_reset;
        step(15);
        rd_chk("R1 reseeding during initial seed", 8'h04, 32'h8000_0000);
        step(1);
        rd_chk("R1 seeded after initial seed", 8'h04, 32'h0000_0200);
        rd_chk("R1 seed-done status", 8'h14, 32'h2);
        rd_chk("R1 command idle", 8'h00, 32'h0);
        rd_chk("R1 result word clear", 8'h20, 32'h0);
    endtask

    task automatic t_ident;
        rd_chk("R2 version", 8'hF0, 32'h0000_46BC);
        rd_chk("R2 unmapped 0x0C", 8'h0C, 32'h0);
        rd_chk("R2 unmapped 0x44", 8'h44, 32'h0);
    endtask

    task automatic t_narrow_first;
        logic [31:0] d;
        gen_req(1'b0, 32'h0000_0200);
        for (int i = 0; i < 4; i++) begin
            rd(8'h20 + 8'(4 * i), d);
            chk_ne("R5 narrow word nonzero", d, 32'h0);
        end
        step(1);
        rd_chk("R5 word 4 zero in narrow mode", 8'h30, 32'h0);
        rd_chk("R4 R7 status bits", 8'h14, 32'h3);
    endtask

    task automatic t_wide;
        logic [31:0] d;
        gen_req(1'b1, 32'h0000_0200);
        rd(8'h3C, d);
        chk_ne("R5 wide word 7 nonzero", d, 32'h0);
        rd(8'h30, d);
        chk_ne("R5 wide word 4 nonzero", d, 32'h0);
        rd(8'h20, saved_w0);
    endtask

    task automatic t_narrow_again;
        logic [31:0] d;
        gen_req(1'b0, 32'h0000_0200);
        rd_chk("R5 word 7 hidden after narrow", 8'h3C, 32'h0);
        rd_chk("R5 word 4 hidden after narrow", 8'h30, 32'h0);
        rd(8'h20, d);
        chk_ne("R6 word 0 changed", d, saved_w0);
    endtask

    task automatic t_istat;
        rd_chk("R7 status before clear", 8'h14, 32'h3);
        wr(8'h14, 32'h1);
        rd_chk("R7 clear bit 0 only", 8'h14, 32'h2);
        wr(8'h14, 32'h0);
        rd_chk("R7 zero write keeps bits", 8'h14, 32'h2);
        wr(8'h14, 32'h2);
        rd_chk("R7 clear bit 1", 8'h14, 32'h0);
    endtask

    task automatic t_seed_hold;
        wr(8'h00, 32'h2);
        wr(8'h00, 32'h1);
        rd_chk("R8 reseeding after command", 8'h04, 32'h8000_0200);
        rd_chk("R10 generate held", 8'h00, 32'h1);
        step(15);
        rd_chk("R8 still reseeding at cycle 16", 8'h04, 32'h8000_0200);
        rd_chk("R10 still held", 8'h00, 32'h1);
        step(1);
        rd_chk("R8 idle after reseed", 8'h04, 32'h0000_0200);
        rd_chk("R8 seed-done set", 8'h14, 32'h2);
        step(1);
        rd_chk("R10 held request starts", 8'h04, 32'h4000_0200);
        rd_chk("R10 command consumed", 8'h00, 32'h0);
        step(4);
        rd_chk("R4 ready after held request", 8'h14, 32'h3);
    endtask

    task automatic t_auto;
        wr(8'h14, 32'h3);
        wr(8'h00, 32'h2);
        step(1);
        step(16);
        rd_chk("R8 idle before limit test", 8'h04, 32'h0000_0200);
        wr(8'h60, 32'd3);
        rd_chk("R9 limit reads back", 8'h60, 32'd3);
        gen_req(1'b1, 32'h0000_0200);
        gen_req(1'b1, 32'h8000_0200);
        step(15);
        rd_chk("R9 auto reseed still running", 8'h04, 32'h8000_0200);
        step(1);
        rd_chk("R9 auto reseed finished", 8'h04, 32'h0000_0200);
        rd_chk("R9 seed-done after auto reseed", 8'h14, 32'h3);
        wr(8'h60, 32'd0);
        gen_req(1'b1, 32'h0000_0200);
        gen_req(1'b1, 32'h0000_0200);
    endtask

    task automatic t_irq;
        rd_chk("R11 status both set", 8'h14, 32'h3);
        chk("R11 no enables", {31'b0, irq}, 32'h0);
        wr(8'h10, 32'h0000_0001);
        chk("R11 no global enable", {31'b0, irq}, 32'h0);
        wr(8'h10, 32'h8000_0001);
        chk("R11 ready interrupt", {31'b0, irq}, 32'h1);
        rd_chk("R11 enable readback", 8'h10, 32'h8000_0001);
        wr(8'h14, 32'h1);
        chk("R11 ready cleared, seed not enabled", {31'b0, irq}, 32'h0);
        wr(8'h10, 32'h8000_0002);
        chk("R11 seed-done interrupt", {31'b0, irq}, 32'h1);
        wr(8'h14, 32'h2);
        chk("R11 all cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_badcmd;
        wr(8'h00, 32'h3);
        rd_chk("R3 code 3 ignored", 8'h00, 32'h0);
        wr(8'h00, 32'h101);
        rd_chk("R3 upper bits ignored", 8'h00, 32'h0);
        step(1);
        rd_chk("R3 no action taken", 8'h04, 32'h0000_0200);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_narrow_first();
        t_wide();
        t_narrow_again();
        t_istat();
        t_seed_hold();
        t_auto();
        t_irq();
        t_badcmd();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule